// File: doc/BRIEF.md
# Separable 8x8 Prediction Smoothing Filter

This block smooths one 8x8 block of 8-bit unsigned prediction pixels, taken from the previous frame, before the residual is added to it. The weights [1 2 1] are applied along each row and then down each column. In a given direction, a pixel on the block border is not mixed with its neighbours, so the weights there are [0 1 0]. As a result, interior pixels have a total gain of 16, border pixels that are not corners have a gain of 4, and the four corners have a gain of 1. The weighted sum is scaled back to 8 bits with rounding: half the gain is added, then the result is shifted right.

Pixels arrive in raster order, 64 per block, through a valid/ready handshake. A filter-enable bit is taken together with the first pixel of each block. When that bit is clear, the whole block leaves the filter unchanged. The complete block is held in an internal buffer. Output starts one cycle after the last input pixel is accepted and leaves in raster order through a second valid/ready handshake with a registered output. The next block can start filling as soon as the last output pixel has been loaded into the output register.

Top module: `loop_filter8x8`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. A reset in the middle of a block discards the partial block, and the next accepted pixel is pixel 0 of a new block.
- R2: `in_ready` stays 1 until 64 input pixels have been accepted. After the 64th is accepted, `in_ready` is 0 until the output phase ends.
- R3: `out_valid` goes high in the second cycle after the edge that accepts input pixel 63. Output pixels leave in raster order (index = row*8 + column), and with `out_ready` held at 1 there is one pixel per cycle, so the block takes 64 cycles.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_pix` holds its value.
- R5: If `in_filt` was 0 when pixel 0 was accepted, each output pixel equals the input pixel with the same index.
- R6: With filtering on, an interior pixel (row and column both in 1..6) becomes (sum over the 3x3 neighbourhood of p*w_row*w_col + 8) >> 4, where the weights are 1, 2, 1.
- R7: With filtering on, a pixel in row 0 or 7 with column 1..6 becomes (left + 2*centre + right + 2) >> 2. A pixel in column 0 or 7 with row 1..6 becomes (up + 2*centre + down + 2) >> 2.
- R8: With filtering on, the four corner pixels pass through unchanged. An all-255 block gives 255 everywhere, so there is no overflow.
- R9: `in_filt` is sampled only when pixel 0 is accepted. Its value on pixels 1..63 has no effect on the output.
- R10: `in_ready` is 1 again by the time the last output pixel of a block is presented on `out_pix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Filter accepts an input pixel |
| in_pix | input | 8 | Input pixel, raster order |
| in_filt | input | 1 | Filter enable, used with pixel 0 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 8 | Output pixel, raster order |

## Verification
Input acceptance is a same-cycle decision. The first output appears on the port at the second clock edge after the edge that takes pixel 63: one edge moves the control into the output phase and the next loads the output register. After that, each output pixel is due one edge after the previous one is consumed. The bench drives and samples on the falling edge. It confirms that `out_valid` is still low one half-cycle after the last input and high one full cycle later. With `out_ready` held high it expects exactly 64 consecutive output samples. When it stalls the output, it compares the held pixel on the following falling edge. Every expected pixel comes from a divide-by-gain model over the block the bench itself generated.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } lf_state_e;

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int NPIX  = 64,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_filt,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             load,
  output logic             filt_q,
  output logic             out_valid
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  lf_state_e        state_q;
  logic [IDX_W-1:0] wr_cnt_q;
  logic [IDX_W-1:0] rd_cnt_q;
  logic             ov_q;

  assign in_ready  = (state_q == ST_FILL);
  assign wr_en     = in_valid && in_ready;
  assign wr_idx    = wr_cnt_q;
  assign rd_idx    = rd_cnt_q;
  assign load      = (state_q == ST_DRAIN) && (!ov_q || out_ready);
  assign out_valid = ov_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FILL;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      filt_q   <= 1'b0;
      ov_q     <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_cnt_q == '0) filt_q <= in_filt;
        if (wr_cnt_q == LAST) begin
          wr_cnt_q <= '0;
          state_q  <= ST_DRAIN;
        end else begin
          wr_cnt_q <= wr_cnt_q + 1'b1;
        end
      end
      if (load) begin
        ov_q <= 1'b1;
        if (rd_cnt_q == LAST) begin
          rd_cnt_q <= '0;
          state_q  <= ST_FILL;
        end else begin
          rd_cnt_q <= rd_cnt_q + 1'b1;
        end
      end else if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lf_buffer.sv
module lf_buffer #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 64,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [PIX_W-1:0]           wr_data,
  output logic [NPIX-1:0][PIX_W-1:0] blk
);

  logic [NPIX-1:0][PIX_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_data;
  end

  assign blk = store_q;

endmodule

// File: rtl/lf_kernel.sv
module lf_kernel #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int NPIX  = BLK * BLK,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic [NPIX-1:0][PIX_W-1:0] blk,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       filt_en,
  output logic [PIX_W-1:0]           pix
);

  localparam int CRD_W = $clog2(BLK);
  localparam int SUM_W = PIX_W + 5;
  localparam logic [CRD_W-1:0] EDGE_HI = CRD_W'(BLK - 1);

  logic [CRD_W-1:0] row, col, rm, rp, cm, cp;
  logic             row_e, col_e;
  logic [SUM_W-1:0] hs [3];
  logic [SUM_W-1:0] vsum, rnd, scaled;
  logic [2:0]       sh;

  assign row   = idx[IDX_W-1:CRD_W];
  assign col   = idx[CRD_W-1:0];
  assign rm    = row - 1'b1;
  assign rp    = row + 1'b1;
  assign cm    = col - 1'b1;
  assign cp    = col + 1'b1;
  assign row_e = (row == '0) || (row == EDGE_HI);
  assign col_e = (col == '0) || (col == EDGE_HI);

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      logic [CRD_W-1:0] rsel;
      rsel = (k == 0) ? rm : ((k == 1) ? row : rp);
      if (col_e)
        hs[k] = SUM_W'(blk[{rsel, col}]);
      else
        hs[k] = SUM_W'(blk[{rsel, cm}]) + (SUM_W'(blk[{rsel, col}]) << 1)
              + SUM_W'(blk[{rsel, cp}]);
    end
  end

  always_comb begin
    vsum   = row_e ? hs[1] : (hs[0] + (hs[1] << 1) + hs[2]);
    sh     = (col_e ? 3'd0 : 3'd2) + (row_e ? 3'd0 : 3'd2);
    rnd    = (sh == 3'd0) ? '0 : (SUM_W'(1) << (sh - 3'd1));
    scaled = (vsum + rnd) >> sh;
    pix    = filt_en ? scaled[PIX_W-1:0] : blk[idx];
  end

endmodule

// File: rtl/loop_filter8x8.sv
module loop_filter8x8 #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_filt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix
);

  localparam int NPIX  = BLK * BLK;
  localparam int IDX_W = $clog2(NPIX);

  logic                       wr_en, load, filt_q;
  logic [IDX_W-1:0]           wr_idx, rd_idx;
  logic [NPIX-1:0][PIX_W-1:0] blk;
  logic [PIX_W-1:0]           kern_pix;
  logic [PIX_W-1:0]           out_pix_q;

  lf_ctrl #(.NPIX(NPIX), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_filt(in_filt),
    .out_ready(out_ready), .in_ready(in_ready), .wr_en(wr_en),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .load(load), .filt_q(filt_q),
    .out_valid(out_valid)
  );

  lf_buffer #(.PIX_W(PIX_W), .NPIX(NPIX), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_pix), .blk(blk)
  );

  lf_kernel #(.PIX_W(PIX_W), .BLK(BLK), .NPIX(NPIX), .IDX_W(IDX_W)) u_kern (
    .blk(blk), .idx(rd_idx), .filt_en(filt_q), .pix(kern_pix)
  );

  always_ff @(posedge clk) begin
    if (rst)       out_pix_q <= '0;
    else if (load) out_pix_q <= kern_pix;
  end

  assign out_pix = out_pix_q;

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_pix,
  input logic             in_filt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix
);

  localparam int NPIX = BLK * BLK;
  localparam int CW   = $clog2(NPIX) + 2;

  logic          rst_q = 1'b0;
  logic [CW-1:0] in_cnt, out_cnt, pend;
  logic [PIX_W-1:0] first_pix;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      in_cnt  <= '0;
      out_cnt <= '0;
      pend    <= '0;
    end else begin
      if (in_fire) begin
        if (in_cnt == '0) first_pix <= in_pix;
        in_cnt <= (in_cnt == CW'(NPIX - 1)) ? '0 : in_cnt + 1'b1;
      end
      if (out_fire) out_cnt <= (out_cnt == CW'(NPIX - 1)) ? '0 : out_cnt + 1'b1;
      pend <= pend + CW'(in_fire) - CW'(out_fire);
    end
  end

  // R1: the cycle after a reset edge shows an idle, ready filter
  always_ff @(posedge clk) begin
    if (rst_q) a_r1_reset_idle: assert (!out_valid && in_ready);
  end

  // R4: a stalled output holds
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R2: ready drops only right after an accepted input
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> $past(in_valid));

  // R2: never more pixels in flight than one block holds
  a_r2_pending_bound: assert property (@(posedge clk) disable iff (rst)
    pend <= CW'(NPIX));

  // R8: pixel 0 is a corner, so it always leaves unchanged
  a_r8_corner_first: assert property (@(posedge clk) disable iff (rst)
    out_fire && out_cnt == '0 |-> out_pix == first_pix);

endmodule

bind loop_filter8x8 lf_checker #(.PIX_W(PIX_W), .BLK(BLK)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_pix(in_pix), .in_filt(in_filt), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix)
);

// File: tb/loop_filter8x8_tb.sv
`timescale 1ns/1ps
module loop_filter8x8_tb;

  localparam int BLK  = 8;
  localparam int NPIX = BLK * BLK;

  // {pattern[2:0], filter, stall}
  localparam logic [4:0] VEC [6] = '{
    {3'd0, 1'b1, 1'b0},
    {3'd1, 1'b1, 1'b1},
    {3'd1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0},
    {3'd3, 1'b1, 1'b1},
    {3'd4, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, in_valid, in_ready, in_filt, out_valid, out_ready;
  logic [7:0] in_pix, out_pix;

  loop_filter8x8 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_filt(in_filt), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] blk [NPIX];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int pat, input int i);
    int r = i / BLK;
    int c = i % BLK;
    case (pat)
      0:       return 8'((i * 4) & 255);
      1:       return 8'(((i * 37 + 11) ^ (i << 3)) & 255);
      2:       return 8'd255;
      3:       return ((r + c) % 2 == 1) ? 8'd255 : 8'd0;
      default: return 8'(((i * 113) ^ 8'h5a) & 255);
    endcase
  endfunction

  function automatic int expect_pix(input int i, input bit f);
    int r = i / BLK;
    int c = i % BLK;
    int acc = 0;
    int gain = 0;
    if (!f) return int'(blk[i]);
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int wr, wc;
        if (r == 0 || r == BLK - 1) wr = (dr == 0) ? 1 : 0;
        else                        wr = (dr == 0) ? 2 : 1;
        if (c == 0 || c == BLK - 1) wc = (dc == 0) ? 1 : 0;
        else                        wc = (dc == 0) ? 2 : 1;
        if (wr * wc != 0) acc += wr * wc * int'(blk[(r + dr) * BLK + c + dc]);
        gain += wr * wc;
      end
    end
    return (acc + gain / 2) / gain;
  endfunction

  function automatic string cls(input int i, input bit f);
    int r = i / BLK;
    int c = i % BLK;
    bit re = (r == 0 || r == BLK - 1);
    bit ce = (c == 0 || c == BLK - 1);
    if (!f)       return "R5 bypass";
    if (re && ce) return "R8 corner";
    if (re || ce) return "R7 edge";
    return "R6 interior";
  endfunction

  // R9: in_filt is inverted on every pixel after pixel 0
  task automatic send_block(input bit f);
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      check(in_ready == 1'b1, $sformatf("R2 ready px%0d", i), in_ready, 1);
      in_valid = 1'b1;
      in_pix   = blk[i];
      in_filt  = (i == 0) ? f : ~f;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_filt  = 1'b0;
    check(in_ready == 1'b0, "R2 ready low after block", in_ready, 0);
    check(out_valid == 1'b0, "R3 not yet valid", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R3 first output due", out_valid, 1);
  endtask

  task automatic collect(input bit stall, input bit f);
    int got = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [7:0] hp = '0;
    while (got < NPIX && cyc < 2000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (held) begin
        check(out_valid && out_pix == hp, "R4 held pixel", out_pix, hp);
        held = 1'b0;
      end
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        int e = expect_pix(got, f);
        check(out_pix == 8'(e), $sformatf("%s R9 px%0d", cls(got, f), got), out_pix, e);
        if (got == NPIX - 1) check(in_ready == 1'b1, "R10 ready on last output", in_ready, 1);
        got++;
      end else if (out_valid) begin
        held = 1'b1;
        hp   = out_pix;
      end
    end
    if (!stall) check(cyc == NPIX, "R3 one pixel per cycle", cyc, NPIX);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R3 block ends", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_pix = '0; in_filt = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    rst = 1'b0;

    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < NPIX; i++) blk[i] = gen(int'(VEC[v][4:2]), i);
      send_block(VEC[v][1]);
      collect(VEC[v][0], VEC[v][1]);
    end

    // R1: reset in the middle of a block, then a clean block
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_pix = 8'hee; in_filt = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-block reset",
          {out_valid, in_ready}, 1);
    for (int i = 0; i < NPIX; i++) blk[i] = gen(1, NPIX - 1 - i);
    send_block(1'b1);
    collect(1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule